// File: doc/BRIEF.md
# Exception Resume Address Calculator

This block works out the address at which a processor should continue after an exception handler has finished. The handler supplies four things: the saved exception PC, a flag that says whether the trapped instruction sat in the delay slot of a control transfer, an action code (retry, skip or simulate), and the instruction word fetched from the saved PC. It also supplies two operand values captured from the register file at the moment of the trap. The block then returns the resume address.

When the flag is clear, or the action is retry, the answer is only an offset from the saved PC. When the flag is set and the trapped instruction is to be skipped or simulated, the transfer at the saved PC has to be replayed. The block decodes that word, evaluates its condition against the trap-time operands, and picks the branch target, the jump target or the address after the delay slot. The handler must capture the operands before it emulates anything, because the emulated instruction may overwrite a register that the branch tests. A word that is not a recognised transfer is flagged and falls back to the address after the delay slot.

A one-cycle `start` pulse launches a calculation. The result is registered and appears with a one-cycle valid pulse on the next cycle. A new request may be issued every cycle.

Top module: `exc_resume_calc`

## Requirements
- R1: With the delay-slot flag clear, action 2'b00 (retry) or 2'b11 (reserved, treated as retry) resumes at the saved PC, and action 2'b01 (skip) or 2'b10 (simulate) resumes at saved PC + 4. The instruction word is ignored and `bad_branch` stays 0.
- R2: With the flag set and action retry (2'b00 or 2'b11), the result is the saved PC, so the transfer runs again. `bad_branch` stays 0 whatever the word holds.
- R3: With the flag set and action skip or simulate, a relative branch produces one of two addresses. If taken, it resumes at saved PC + 4 + (sign-extended offset bits [15:0] shifted left by 2). If not taken, it resumes at saved PC + 8. All arithmetic wraps modulo 2^32.
- R4: The branch conditions use the primary opcode in bits [31:26] and compare signed 32-bit values:
  - 6'h04 taken when A == B.
  - 6'h05 taken when A != B.
  - 6'h06 taken when A <= 0.
  - 6'h07 taken when A > 0.
  - 6'h01 selects its condition through bits [20:16]: 5'h00 or 5'h10 is taken when A < 0, and 5'h01 or 5'h11 is taken when A >= 0.
- R5: The register selector in bits [25:21] names operand A and the selector in bits [20:16] names operand B. A selector of 0 denotes the constant-zero register, and the operand is then read as 0 whatever value is supplied. As a result, the link form "A >= 0" (opcode 6'h01, code 5'h11) with selector 0 is always taken.
- R6: Absolute jumps (opcode 6'h02 or 6'h03) resume at the upper 4 bits of (saved PC + 4) joined with bits [25:0] of the word shifted left by 2.
- R7: Register jumps (opcode 6'h00 with function bits [5:0] equal to 6'h08 or 6'h09) resume at operand A, after the selector-0 rule of R5 is applied.
- R8: With the flag set and action skip or simulate, any other word raises `bad_branch` together with the result, and the address is saved PC + 8. `bad_branch` is 0 in every other case.
- R9: `resume_valid` is high for exactly the cycle after each cycle in which `start` is high. Without `start`, `resume_addr` and `bad_branch` hold their values.
- R10: While reset (`rst_n` low) is asserted, `resume_valid`, `resume_addr` and `bad_branch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| epc | input | 32 | Saved exception PC |
| in_delay_slot | input | 1 | Trapped instruction sat in a delay slot |
| action | input | 2 | 00 retry, 01 skip, 10 simulate, 11 retry |
| branch_word | input | 32 | Instruction word fetched from the saved PC |
| op_a | input | 32 | Trap-time value of the register named by bits [25:21] |
| op_b | input | 32 | Trap-time value of the register named by bits [20:16] |
| resume_addr | output | 32 | Computed resume address |
| resume_valid | output | 1 | Result strobe, one cycle after `start` |
| bad_branch | output | 1 | Word at the saved PC was not a recognised transfer |

## Verification
Properties in the RTL check on every cycle the address rules that do not depend on decoding the word. These are the retry and PC + 4 results, the valid strobe following `start`, the hold of outputs when idle, the PC + 8 fallback whenever `bad_branch` is raised, and that `bad_branch` never appears unless the flag is set with a skip or simulate action. The scoreboard scenarios are the only evidence for the per-opcode behaviour:
- taken and not-taken outcomes of each signed condition, including the zero and most-negative boundaries;
- negative offsets;
- the constant-zero selector forcing a link branch taken;
- an absolute jump whose upper bits come from a carry out of the PC + 4 increment;
- register jumps.

// File: rtl/resume_pkg.sv
package resume_pkg;

   localparam int unsigned WORD_W = 32;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_REGIMM  = 6'h01;
   localparam logic [5:0] OPC_JABS    = 6'h02;
   localparam logic [5:0] OPC_JABSL   = 6'h03;
   localparam logic [5:0] OPC_BEQ     = 6'h04;
   localparam logic [5:0] OPC_BNE     = 6'h05;
   localparam logic [5:0] OPC_BLEZ    = 6'h06;
   localparam logic [5:0] OPC_BGTZ    = 6'h07;
   localparam logic [5:0] FN_JREG     = 6'h08;
   localparam logic [5:0] FN_JREGL    = 6'h09;

   typedef enum logic [1:0] {
      ACT_RETRY = 2'b00,
      ACT_SKIP  = 2'b01,
      ACT_SIM   = 2'b10,
      ACT_RSVD  = 2'b11
   } action_e;

   typedef enum logic [1:0] {
      K_NONE,
      K_REL,
      K_ABS,
      K_REG
   } kind_e;

   typedef enum logic [2:0] {
      C_EQ,
      C_NE,
      C_LEZ,
      C_GTZ,
      C_LTZ,
      C_GEZ
   } cond_e;

   typedef struct packed {
      kind_e kind;
      cond_e cond;
   } xfer_t;

endpackage

// File: rtl/resume_decode.sv
module resume_decode
   import resume_pkg::*;
(
   input  logic [15:0] word_hi,
   input  logic [5:0]  word_fn,
   output xfer_t       xfer,
   output logic        sel_a_zero,
   output logic        sel_b_zero
);
   logic [5:0] opc;
   logic [4:0] sel_a;
   logic [4:0] sel_b;

   assign opc   = word_hi[15:10];
   assign sel_a = word_hi[9:5];
   assign sel_b = word_hi[4:0];

   assign sel_a_zero = (sel_a == 5'd0);
   assign sel_b_zero = (sel_b == 5'd0);

   always_comb begin
      xfer.kind = K_NONE;
      xfer.cond = C_EQ;
      unique case (opc)
         OPC_BEQ:  begin xfer.kind = K_REL; xfer.cond = C_EQ;  end
         OPC_BNE:  begin xfer.kind = K_REL; xfer.cond = C_NE;  end
         OPC_BLEZ: begin xfer.kind = K_REL; xfer.cond = C_LEZ; end
         OPC_BGTZ: begin xfer.kind = K_REL; xfer.cond = C_GTZ; end
         OPC_REGIMM: begin
            unique case (sel_b)
               5'h00, 5'h10: begin xfer.kind = K_REL; xfer.cond = C_LTZ; end
               5'h01, 5'h11: begin xfer.kind = K_REL; xfer.cond = C_GEZ; end
               default:      xfer.kind = K_NONE;
            endcase
         end
         OPC_JABS, OPC_JABSL: xfer.kind = K_ABS;
         OPC_SPECIAL: begin
            if (word_fn == FN_JREG || word_fn == FN_JREGL)
               xfer.kind = K_REG;
         end
         default: xfer.kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/resume_cond.sv
module resume_cond
   import resume_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter bit          SIGN_TEST = 1'b1
) (
   input  logic [XLEN-1:0] val_a,
   input  logic [XLEN-1:0] val_b,
   input  cond_e           cond,
   output logic            taken
);
   logic is_neg;
   logic is_zero;
   logic is_eq;

   assign is_eq = (val_a == val_b);

   generate
      if (SIGN_TEST) begin : g_signbit
         assign is_neg  = val_a[XLEN-1];
         assign is_zero = ~|val_a;
      end else begin : g_compare
         assign is_neg  = ($signed(val_a) < $signed({XLEN{1'b0}}));
         assign is_zero = (val_a == {XLEN{1'b0}});
      end
   endgenerate

   always_comb begin
      unique case (cond)
         C_EQ:    taken = is_eq;
         C_NE:    taken = ~is_eq;
         C_LEZ:   taken = is_neg | is_zero;
         C_GTZ:   taken = ~is_neg & ~is_zero;
         C_LTZ:   taken = is_neg;
         C_GEZ:   taken = ~is_neg;
         default: taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/resume_target.sv
module resume_target #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned OFF_W   = 16,
   parameter int unsigned IDX_W   = 26,
   parameter int unsigned SHIFT   = 2
) (
   input  logic [XLEN-1:0]  epc,
   input  logic [OFF_W-1:0] offset,
   input  logic [IDX_W-1:0] index,
   output logic [XLEN-1:0]  seq_addr,
   output logic [XLEN-1:0]  after_addr,
   output logic [XLEN-1:0]  rel_addr,
   output logic [XLEN-1:0]  abs_addr
);
   localparam int unsigned STEP     = 1 << SHIFT;
   localparam int unsigned REGION_W = XLEN - IDX_W - SHIFT;

   logic [XLEN-1:0] off_ext;

   assign seq_addr   = epc + XLEN'(STEP);
   assign after_addr = epc + XLEN'(2 * STEP);
   assign off_ext    = {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset} << SHIFT;
   assign rel_addr   = seq_addr + off_ext;
   assign abs_addr   = {seq_addr[XLEN-1 -: REGION_W], index, {SHIFT{1'b0}}};
endmodule

// File: rtl/exc_resume_calc.sv
module exc_resume_calc
   import resume_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned IDX_W     = 26,
   parameter int unsigned INSN_B    = 4,
   parameter bit          SIGN_TEST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [XLEN-1:0]  epc,
   input  logic             in_delay_slot,
   input  logic [1:0]       action,
   input  logic [31:0]      branch_word,
   input  logic [XLEN-1:0]  op_a,
   input  logic [XLEN-1:0]  op_b,
   output logic [XLEN-1:0]  resume_addr,
   output logic             resume_valid,
   output logic             bad_branch
);
   localparam int unsigned SHIFT    = $clog2(INSN_B);
   localparam int unsigned REGION_W = XLEN - IDX_W - SHIFT;

   generate
      if (REGION_W < 1 || REGION_W >= XLEN) begin : g_bad_region
         $error("exc_resume_calc: index width leaves no region bits");
      end
      if (OFF_W + SHIFT > XLEN || OFF_W > 16) begin : g_bad_offset
         $error("exc_resume_calc: offset field does not fit");
      end
      if ((1 << SHIFT) != INSN_B) begin : g_bad_step
         $error("exc_resume_calc: instruction size must be a power of two");
      end
      if (XLEN != WORD_W) begin : g_bad_xlen
         $error("exc_resume_calc: address width must match word width");
      end
   endgenerate

   xfer_t           xfer;
   logic            a_zero, b_zero;
   logic [XLEN-1:0] val_a, val_b;
   logic            taken;
   logic [XLEN-1:0] seq_addr, after_addr, rel_addr, abs_addr;
   logic [XLEN-1:0] nxt_addr;
   logic            nxt_bad;
   logic            advance;
   action_e         act;

   resume_decode u_decode (
      .word_hi    (branch_word[31:16]),
      .word_fn    (branch_word[5:0]),
      .xfer       (xfer),
      .sel_a_zero (a_zero),
      .sel_b_zero (b_zero)
   );

   assign val_a = a_zero ? '0 : op_a;
   assign val_b = b_zero ? '0 : op_b;

   resume_cond #(.XLEN(XLEN), .SIGN_TEST(SIGN_TEST)) u_cond (
      .val_a (val_a),
      .val_b (val_b),
      .cond  (xfer.cond),
      .taken (taken)
   );

   resume_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .SHIFT(SHIFT)) u_target (
      .epc        (epc),
      .offset     (branch_word[OFF_W-1:0]),
      .index      (branch_word[IDX_W-1:0]),
      .seq_addr   (seq_addr),
      .after_addr (after_addr),
      .rel_addr   (rel_addr),
      .abs_addr   (abs_addr)
   );

   assign act     = action_e'(action);
   assign advance = (act == ACT_SKIP) || (act == ACT_SIM);

   always_comb begin
      nxt_addr = epc;
      nxt_bad  = 1'b0;
      if (advance) begin
         if (!in_delay_slot) begin
            nxt_addr = seq_addr;
         end else begin
            unique case (xfer.kind)
               K_REL:   nxt_addr = taken ? rel_addr : after_addr;
               K_ABS:   nxt_addr = abs_addr;
               K_REG:   nxt_addr = val_a;
               default: begin
                  nxt_addr = after_addr;
                  nxt_bad  = 1'b1;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resume_addr  <= '0;
         resume_valid <= 1'b0;
         bad_branch   <= 1'b0;
      end else begin
         resume_valid <= start;
         if (start) begin
            resume_addr <= nxt_addr;
            bad_branch  <= nxt_bad;
         end
      end
   end

   // R10: outputs cleared while in reset
   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |=> (!resume_valid && resume_addr == '0 && !bad_branch));

   p_start_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> resume_valid);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (!resume_valid && $stable(resume_addr) && $stable(bad_branch)));

   p_retry_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !in_delay_slot && !(action == 2'b01 || action == 2'b10))
      |=> (resume_addr == $past(epc) && !bad_branch));

   p_step_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !in_delay_slot && (action == 2'b01 || action == 2'b10))
      |=> (resume_addr == $past(epc) + XLEN'(INSN_B) && !bad_branch));

   p_retry_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && in_delay_slot && !(action == 2'b01 || action == 2'b10))
      |=> (resume_addr == $past(epc) && !bad_branch));

   p_bad_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_valid && bad_branch) |-> (resume_addr == $past(epc) + XLEN'(2 * INSN_B)));

   p_bad_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !(in_delay_slot && (action == 2'b01 || action == 2'b10))) |=> !bad_branch);

endmodule

// File: tb/tb_exc_resume_calc.sv
`timescale 1ns/1ps
module tb_exc_resume_calc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] epc = '0;
   logic        in_delay_slot = 1'b0;
   logic [1:0]  action = 2'b00;
   logic [31:0] branch_word = '0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [31:0] resume_addr;
   logic        resume_valid;
   logic        bad_branch;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [31:0] addr;
      logic        bad;
      string       req;
   } exp_t;

   exp_t sb_q[$];

   always #4 clk = ~clk;

   exc_resume_calc dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .epc           (epc),
      .in_delay_slot (in_delay_slot),
      .action        (action),
      .branch_word   (branch_word),
      .op_a          (op_a),
      .op_b          (op_b),
      .resume_addr   (resume_addr),
      .resume_valid  (resume_valid),
      .bad_branch    (bad_branch)
   );

   function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [15:0] imm);
      return {op, ra, rb, imm};
   endfunction

   // Reference model written from the requirements
   function automatic exp_t model(input logic [31:0] e, input logic bd, input logic [1:0] act,
                                  input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                                  input string req);
      exp_t r;
      logic [31:0] pc4 = e + 32'd4;
      logic [31:0] pc8 = e + 32'd8;
      logic signed [31:0] sa = (w[25:21] == 5'd0) ? 32'sd0 : $signed(a);
      logic signed [31:0] sb = (w[20:16] == 5'd0) ? 32'sd0 : $signed(b);
      logic [31:0] tgt = pc4 + {{14{w[15]}}, w[15:0], 2'b00};
      logic tk;
      r.req = req;
      r.bad = 1'b0;
      if (!(act == 2'b01 || act == 2'b10)) begin
         r.addr = e;
      end else if (!bd) begin
         r.addr = pc4;
      end else begin
         r.addr = pc8;
         tk = 1'b0;
         case (w[31:26])
            6'h04: begin tk = (sa == sb); r.addr = tk ? tgt : pc8; end
            6'h05: begin tk = (sa != sb); r.addr = tk ? tgt : pc8; end
            6'h06: begin tk = (sa <= 0);  r.addr = tk ? tgt : pc8; end
            6'h07: begin tk = (sa > 0);   r.addr = tk ? tgt : pc8; end
            6'h01: begin
               if (w[20:16] == 5'h00 || w[20:16] == 5'h10) begin
                  tk = (sa < 0); r.addr = tk ? tgt : pc8;
               end else if (w[20:16] == 5'h01 || w[20:16] == 5'h11) begin
                  tk = (sa >= 0); r.addr = tk ? tgt : pc8;
               end else r.bad = 1'b1;
            end
            6'h02, 6'h03: r.addr = {pc4[31:28], w[25:0], 2'b00};
            6'h00: begin
               if (w[5:0] == 6'h08 || w[5:0] == 6'h09) r.addr = sa;
               else r.bad = 1'b1;
            end
            default: r.bad = 1'b1;
         endcase
      end
      return r;
   endfunction

   task automatic drive(input logic [31:0] e, input logic bd, input logic [1:0] act,
                        input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input string req);
      sb_q.push_back(model(e, bd, act, w, a, b, req));
      @(negedge clk);
      epc = e; in_delay_slot = bd; action = act; branch_word = w; op_a = a; op_b = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Monitor: compares every result against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && resume_valid) begin
         n_cmp++;
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected valid: actual=1 expected=0");
         end else begin
            exp_t x;
            x = sb_q.pop_front();
            if (resume_addr !== x.addr || bad_branch !== x.bad) begin
               n_bad++;
               $display("FAIL %s: actual addr=%h bad=%b expected addr=%h bad=%b",
                        x.req, resume_addr, bad_branch, x.addr, x.bad);
            end
         end
      end
   end

   task automatic check(input logic cond, input string req, input logic [31:0] act_v,
                        input logic [31:0] exp_v);
      n_cmp++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(resume_valid === 1'b0, "R10 valid", {31'd0, resume_valid}, 32'd0);
      check(resume_addr === 32'd0, "R10 addr", resume_addr, 32'd0);
      check(bad_branch === 1'b0, "R10 bad", {31'd0, bad_branch}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: flag clear, word ignored
      drive(32'h0040_1000, 1'b0, 2'b00, 32'hFFFF_FFFF, 32'd1, 32'd2, "R1 retry");
      drive(32'h0040_1000, 1'b0, 2'b01, 32'hFFFF_FFFF, 32'd1, 32'd2, "R1 skip");
      drive(32'h0040_1000, 1'b0, 2'b10, mk_i(6'h04, 5'd4, 5'd5, 16'h0010), 32'd7, 32'd7, "R1 simulate");
      drive(32'h0040_1000, 1'b0, 2'b11, 32'h0000_0000, 32'd0, 32'd0, "R1 reserved");
      drive(32'hFFFF_FFFC, 1'b0, 2'b01, 32'd0, 32'd0, 32'd0, "R1 wrap");
      // R2: flag set, retry
      drive(32'h0040_2000, 1'b1, 2'b00, mk_i(6'h04, 5'd4, 5'd5, 16'h0010), 32'd7, 32'd7, "R2 retry");
      drive(32'h0040_2000, 1'b1, 2'b11, 32'hFFFF_FFFF, 32'd7, 32'd7, "R2 reserved");
      // R3 / R4 relative branches
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h04, 5'd4, 5'd5, 16'h0010), 32'd7, 32'd7, "R3 eq taken");
      drive(32'h0040_3000, 1'b1, 2'b10, mk_i(6'h04, 5'd4, 5'd5, 16'hFFFE), 32'd7, 32'd7, "R3 neg offset");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h05, 5'd4, 5'd5, 16'h0020), 32'd9, 32'd9, "R4 ne not taken");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h05, 5'd4, 5'd5, 16'h0020), 32'd9, 32'd8, "R4 ne taken");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h06, 5'd3, 5'd0, 16'h0100), 32'hFFFF_FFFF, 32'd0, "R4 lez neg");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h06, 5'd3, 5'd0, 16'h0100), 32'd1, 32'd0, "R4 lez pos");
      drive(32'h0040_3000, 1'b1, 2'b10, mk_i(6'h07, 5'd3, 5'd0, 16'h0100), 32'd0, 32'd0, "R4 gtz zero");
      drive(32'h0040_3000, 1'b1, 2'b10, mk_i(6'h07, 5'd3, 5'd0, 16'h0100), 32'h7FFF_FFFF, 32'd0, "R4 gtz max");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h01, 5'd3, 5'h00, 16'h8000), 32'h8000_0000, 32'd0, "R4 ltz min");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h01, 5'd3, 5'h01, 16'h0004), 32'hFFFF_FFFF, 32'd0, "R4 gez neg");
      drive(32'h0040_3000, 1'b1, 2'b01, mk_i(6'h01, 5'd3, 5'h10, 16'h0004), 32'd5, 32'd0, "R4 ltz link pos");
      // R5 constant-zero selector
      drive(32'h0040_4000, 1'b1, 2'b10, mk_i(6'h01, 5'd0, 5'h11, 16'h0040), 32'hFFFF_FFFB, 32'd0, "R5 link always");
      drive(32'h0040_4000, 1'b1, 2'b10, mk_i(6'h04, 5'd0, 5'd0, 16'h0008), 32'd3, 32'd4, "R5 eq zero regs");
      drive(32'h0040_4000, 1'b1, 2'b10, mk_i(6'h05, 5'd6, 5'd0, 16'h0008), 32'd0, 32'd4, "R5 ne zero b");
      // R6 absolute jumps
      drive(32'hA000_0FFC, 1'b1, 2'b01, {6'h02, 26'h012_3456}, 32'd0, 32'd0, "R6 jump");
      drive(32'h0FFF_FFFC, 1'b1, 2'b10, {6'h03, 26'h012_3456}, 32'd0, 32'd0, "R6 region carry");
      // R7 register jumps
      drive(32'h0040_5000, 1'b1, 2'b01, {6'h00, 5'd31, 15'd0, 6'h08}, 32'h8000_1234, 32'd0, "R7 reg");
      drive(32'h0040_5000, 1'b1, 2'b10, {6'h00, 5'd0, 15'd0, 6'h09}, 32'h8000_1234, 32'd0, "R7 reg zero");
      // R8 unrecognised words
      drive(32'h0040_6000, 1'b1, 2'b10, mk_i(6'h08, 5'd1, 5'd2, 16'h0003), 32'd0, 32'd0, "R8 other opcode");
      drive(32'h0040_6000, 1'b1, 2'b01, mk_i(6'h01, 5'd1, 5'h02, 16'h0003), 32'd0, 32'd0, "R8 regimm code");
      drive(32'h0040_6000, 1'b1, 2'b01, {6'h00, 5'd1, 15'd0, 6'h20}, 32'd0, 32'd0, "R8 special fn");

      // R9: idle hold after the last result
      held = resume_addr;
      repeat (3) @(negedge clk);
      check(resume_valid === 1'b0, "R9 idle valid", {31'd0, resume_valid}, 32'd0);
      check(resume_addr === held, "R9 idle hold", resume_addr, held);
      check(sb_q.size() == 0, "R9 all results seen", sb_q.size(), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule